// File: doc/BRIEF.md
# Masked Multi-Source Interrupt Controller

This block is a register-bus slave that collects up to ten interrupt request lines and presents them to a processor as one interrupt output. Every source owns one bit position, the same in every register: bit 0 carries source 0, and so on up to bit NUM_SRC-1. Software never writes the enable mask directly. A write of ones to one strobe register sets mask bits, and a write of ones to another clears them. A read-only view returns the current mask. A status register shows which sources are pending, and writing ones to it acknowledges them.

Each source is either level-sensitive or rising-edge-sensitive. The choice is made per source at elaboration through a bit vector parameter. A level source stays pending for as long as its input is high. An edge source latches a single 0-to-1 transition, which is detected against a registered copy of the input. The interrupt output is high whenever at least one pending source is also enabled.

The register bus is word addressed and 32 bits wide. A one-cycle strobe with a write-enable flag is answered by a one-cycle acknowledge on the following cycle, and read data is valid while the acknowledge is high. Typical use is the main interrupt line of a timestamp-capture engine: five buffer-not-empty sources and five acquisition-ready sources, all level triggered. A second use is a two-source, edge-triggered transfer controller.

Top module: `irq_ctrl_top`

## Requirements
- R1: After synchronous reset, the mask, every pending bit and irq_out are all 0.
- R2: A write to word address 0x9 sets each mask bit whose data bit is 1. Data bits of 0 leave their mask bits unchanged.
- R3: A write to word address 0x8 clears each mask bit whose data bit is 1. Data bits of 0 leave their mask bits unchanged.
- R4: A read of word address 0xA returns the mask in bits NUM_SRC-1:0, with 1 meaning enabled. Writes to 0xA have no effect.
- R5: A read of word address 0xB returns the pending bits in bits NUM_SRC-1:0, with 1 meaning pending. A source latches pending whether or not it is enabled.
- R6: A write to 0xB clears each pending bit whose data bit is 1. Bits written with 0 stay pending.
- R7: A level source sets its pending bit on every clock edge at which its input is high. If a clear and a high input meet at the same edge, the clear wins, so a still-high input sets the bit again one cycle later.
- R8: An edge source sets its pending bit only at the first edge where the input is 1 after being 0 at the previous edge. Once cleared, an input held high does not set it again.
- R9: If a rising edge on an edge source meets a clear of that source at the same clock edge, the bit stays pending.
- R10: irq_out is 1 exactly when some source is both pending and enabled, and it follows register updates with no extra cycle of delay.
- R11: bus_ack pulses high for one cycle, the cycle after an accepted strobe. Reads of 0x8, 0x9 and any unmapped address return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_stb | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_ack is high |
| bus_ack | output | 1 | One-cycle access acknowledge |
| src_in | input | NUM_SRC | Raw interrupt source lines |
| irq_out | output | 1 | Combined interrupt request |

## Verification
On every cycle, the embedded properties check the following: the acknowledge handshake, the set, clear and hold rules of the mask, the reset values, the re-arming of level sources while their inputs stay high, the refusal of edge sources to re-arm on a held-high input, and the edge-wins-over-clear priority. What only the directed scenarios can show is the register map as software sees it. This covers read-back of the mask and status at their addresses, zeros from the write-only and unmapped words, a write to the read-only mask being ignored, and irq_out following the AND of pending and enabled bits, including a source that latches while masked. The one-cycle gap between a level clear and its re-arm is also measured at the output pin.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int unsigned REG_ADDR_W = 4;
    localparam int unsigned BUS_DATA_W = 32;

    // Word addresses of the register file
    typedef enum logic [REG_ADDR_W-1:0] {
        RA_MASK_CLR = 4'h8,
        RA_MASK_SET = 4'h9,
        RA_MASK_RD  = 4'hA,
        RA_PENDING  = 4'hB
    } reg_addr_e;

    // Trigger style of one source
    typedef enum logic {
        TRIG_LEVEL = 1'b0,
        TRIG_EDGE  = 1'b1
    } trig_e;

    // One-cycle write strobes decoded from the bus
    typedef struct packed {
        logic mask_set;
        logic mask_clr;
        logic pend_clr;
    } wr_strobe_t;

    function automatic trig_e trig_of(input logic edge_bit);
        return edge_bit ? TRIG_EDGE : TRIG_LEVEL;
    endfunction

    function automatic logic rose(input logic now_v, input logic prev_v);
        return now_v & ~prev_v;
    endfunction

endpackage

// File: rtl/irqc_regif.sv
module irqc_regif
    import irqc_pkg::*;
#(
    parameter int unsigned NUM_SRC = 10,
    parameter int unsigned DATA_W  = 32
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   bus_stb,
    input  logic                   bus_we,
    input  logic [REG_ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]      bus_wdata,
    input  logic [NUM_SRC-1:0]     mask_q,
    input  logic [NUM_SRC-1:0]     pend_q,
    output wr_strobe_t             wstb,
    output logic [NUM_SRC-1:0]     wbits,
    output logic [DATA_W-1:0]      bus_rdata,
    output logic                   bus_ack
);
    localparam int unsigned PAD_W = DATA_W - NUM_SRC;

    logic              ack_q;
    logic              accept;
    logic              rd_go;
    logic [DATA_W-1:0] rd_mux;
    logic [DATA_W-1:0] rdata_q;
    logic [PAD_W-1:0]  wdata_unused;

    assign accept       = bus_stb & ~ack_q;
    assign rd_go        = accept & ~bus_we;
    assign wbits        = bus_wdata[NUM_SRC-1:0];
    assign wdata_unused = bus_wdata[DATA_W-1:NUM_SRC];

    always_comb begin
        wstb          = '0;
        wstb.mask_set = accept & bus_we & (bus_addr == RA_MASK_SET);
        wstb.mask_clr = accept & bus_we & (bus_addr == RA_MASK_CLR);
        wstb.pend_clr = accept & bus_we & (bus_addr == RA_PENDING);
    end

    always_comb begin
        unique case (bus_addr)
            RA_MASK_RD: rd_mux = {{PAD_W{1'b0}}, mask_q};
            RA_PENDING: rd_mux = {{PAD_W{1'b0}}, pend_q};
            default:    rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            ack_q   <= accept;
            rdata_q <= rd_go ? rd_mux : '0;
        end
    end

    assign bus_ack   = ack_q;
    assign bus_rdata = rdata_q;

    // R11: acknowledge is a single-cycle pulse
    p_ack_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        bus_ack |=> !bus_ack);

    // R11: an accepted strobe is acknowledged on the next cycle
    p_ack_follows_r11: assert property (@(posedge clk) disable iff (rst)
        (bus_stb && !bus_ack) |=> bus_ack);

endmodule

// File: rtl/irqc_mask.sv
module irqc_mask
    import irqc_pkg::*;
#(
    parameter int unsigned NUM_SRC = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  wr_strobe_t         wstb,
    input  logic [NUM_SRC-1:0] wbits,
    output logic [NUM_SRC-1:0] mask_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
        end else if (wstb.mask_set) begin
            mask_q <= mask_q | wbits;
        end else if (wstb.mask_clr) begin
            mask_q <= mask_q & ~wbits;
        end
    end

    // R1: mask comes out of reset cleared
    p_mask_reset_r1: assert property (@(posedge clk)
        rst |=> (mask_q == '0));

    // R2: every bit written as 1 to the set register ends up enabled
    p_mask_set_r2: assert property (@(posedge clk) disable iff (rst)
        wstb.mask_set |=> ((mask_q & $past(wbits)) == $past(wbits)));

    // R3: every bit written as 1 to the clear register ends up disabled
    p_mask_clr_r3: assert property (@(posedge clk) disable iff (rst)
        wstb.mask_clr |=> ((mask_q & $past(wbits)) == '0));

    // R4: no other access changes the mask
    p_mask_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!wstb.mask_set && !wstb.mask_clr) |=> $stable(mask_q));

endmodule

// File: rtl/irqc_pending.sv
module irqc_pending
    import irqc_pkg::*;
#(
    parameter int unsigned        NUM_SRC   = 10,
    parameter logic [NUM_SRC-1:0] EDGE_MASK = '0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic               clr_stb,
    input  logic [NUM_SRC-1:0] clr_bits,
    output logic [NUM_SRC-1:0] pend_q
);
    logic [NUM_SRC-1:0] clr_hit;

    assign clr_hit = clr_bits & {NUM_SRC{clr_stb}};

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        if (trig_of(EDGE_MASK[i]) == TRIG_EDGE) begin : g_edge
            logic src_q;
            logic trig;

            // Sampled even in reset so a line high at release is not an edge
            always_ff @(posedge clk) begin
                src_q <= src_in[i];
            end

            assign trig = rose(src_in[i], src_q);

            // A new edge outranks a clear in the same cycle
            always_ff @(posedge clk) begin
                if (rst) begin
                    pend_q[i] <= 1'b0;
                end else if (trig) begin
                    pend_q[i] <= 1'b1;
                end else if (clr_hit[i]) begin
                    pend_q[i] <= 1'b0;
                end
            end

            // R8: a line held high does not re-arm a cleared edge source
            p_edge_no_rearm_r8: assert property (@(posedge clk) disable iff (rst)
                (src_in[i] && $past(src_in[i]) && !pend_q[i]) |=> !pend_q[i]);

            // R9: a fresh edge is captured even against a clear
            p_edge_wins_r9: assert property (@(posedge clk) disable iff (rst)
                (src_in[i] && !$past(src_in[i])) |=> pend_q[i]);
        end else begin : g_level
            // A clear outranks the level; a high line re-arms next cycle
            always_ff @(posedge clk) begin
                if (rst) begin
                    pend_q[i] <= 1'b0;
                end else if (clr_hit[i]) begin
                    pend_q[i] <= 1'b0;
                end else if (src_in[i]) begin
                    pend_q[i] <= 1'b1;
                end
            end

            // R7: a high line without a clear leaves the source pending
            p_level_set_r7: assert property (@(posedge clk) disable iff (rst)
                (src_in[i] && !clr_hit[i]) |=> pend_q[i]);
        end
    end

    // R1: nothing is pending out of reset
    p_pend_reset_r1: assert property (@(posedge clk)
        rst |=> (pend_q == '0));

    // R6: a pending bit only drops through a clear
    p_pend_drop_r6: assert property (@(posedge clk) disable iff (rst)
        !clr_stb |=> (($past(pend_q) & ~pend_q) == '0));

endmodule

// File: rtl/irq_ctrl_top.sv
module irq_ctrl_top
    import irqc_pkg::*;
#(
    parameter int unsigned        NUM_SRC   = 10,
    parameter int unsigned        DATA_W    = BUS_DATA_W,
    parameter logic [NUM_SRC-1:0] EDGE_MASK = '0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  bus_stb,
    input  logic                  bus_we,
    input  logic [REG_ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic                  bus_ack,
    input  logic [NUM_SRC-1:0]    src_in,
    output logic                  irq_out
);
    wr_strobe_t         wstb;
    logic [NUM_SRC-1:0] wbits;
    logic [NUM_SRC-1:0] mask_q;
    logic [NUM_SRC-1:0] pend_q;

    irqc_regif #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_regif (
        .clk       (clk),
        .rst       (rst),
        .bus_stb   (bus_stb),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .mask_q    (mask_q),
        .pend_q    (pend_q),
        .wstb      (wstb),
        .wbits     (wbits),
        .bus_rdata (bus_rdata),
        .bus_ack   (bus_ack)
    );

    irqc_mask #(.NUM_SRC(NUM_SRC)) u_mask (
        .clk    (clk),
        .rst    (rst),
        .wstb   (wstb),
        .wbits  (wbits),
        .mask_q (mask_q)
    );

    irqc_pending #(.NUM_SRC(NUM_SRC), .EDGE_MASK(EDGE_MASK)) u_pending (
        .clk      (clk),
        .rst      (rst),
        .src_in   (src_in),
        .clr_stb  (wstb.pend_clr),
        .clr_bits (wbits),
        .pend_q   (pend_q)
    );

    assign irq_out = |(pend_q & mask_q);

    // R10: with the whole mask cleared the output stays low
    p_irq_masked_r10: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '0) |-> !irq_out);

endmodule

// File: tb/irq_ctrl_top_tb.sv
`timescale 1ns/1ps
module irq_ctrl_top_tb;
    localparam int unsigned NSRC = 10;
    localparam logic [NSRC-1:0] EDGES = 10'h300;  // sources 8 and 9 edge

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_stb = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ack;
    logic [NSRC-1:0] src_in = '0;
    logic        irq_out;

    int unsigned n_chk = 0;
    int unsigned n_fail = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    irq_ctrl_top #(.NUM_SRC(NSRC), .DATA_W(32), .EDGE_MASK(EDGES)) u_dut (
        .clk(clk), .rst(rst), .bus_stb(bus_stb), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ack(bus_ack), .src_in(src_in), .irq_out(irq_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One bus access; optionally changes src_in in the strobe cycle.
    // Returns at the falling edge after the edge that performed the access.
    task automatic bus_op(input logic we, input logic [3:0] a, input logic [31:0] d,
                          input logic upd_src, input logic [NSRC-1:0] new_src,
                          output logic [31:0] rd);
        @(negedge clk);
        bus_stb = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
        if (upd_src) src_in = new_src;
        @(posedge clk);
        @(negedge clk);
        chk("R11 ack high", {31'd0, bus_ack}, 32'd1);
        rd = bus_rdata;
        bus_stb = 1'b0; bus_we = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        logic [31:0] rd;
        bus_op(1'b1, a, d, 1'b0, '0, rd);
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string tag);
        logic [31:0] rd;
        bus_op(1'b0, a, 32'd0, 1'b0, '0, rd);
        chk(tag, rd, exp);
    endtask

    task automatic t_reset;
        chk("R1 irq after reset", {31'd0, irq_out}, 32'd0);
        rd_chk(4'hA, 32'h0, "R1 mask after reset");
        rd_chk(4'hB, 32'h0, "R1 pending after reset");
        @(negedge clk);
        chk("R11 ack one cycle", {31'd0, bus_ack}, 32'd0);
    endtask

    task automatic t_mask_set;
        wr(4'h9, 32'h005);
        rd_chk(4'hA, 32'h005, "R2 set bits 0,2");
        wr(4'h9, 32'h000);
        rd_chk(4'hA, 32'h005, "R2 zero write no effect");
        wr(4'h9, 32'h0F0);
        rd_chk(4'hA, 32'h0F5, "R2 set accumulates");
    endtask

    task automatic t_mask_clr;
        wr(4'h8, 32'h004);
        rd_chk(4'hA, 32'h0F1, "R3 clear bit 2");
        wr(4'h8, 32'h000);
        rd_chk(4'hA, 32'h0F1, "R3 zero write no effect");
        wr(4'hA, 32'h3FF);
        rd_chk(4'hA, 32'h0F1, "R4 mask write ignored");
        rd_chk(4'h8, 32'h0, "R11 clear register reads 0");
        rd_chk(4'h9, 32'h0, "R11 set register reads 0");
        rd_chk(4'h3, 32'h0, "R11 unmapped reads 0");
    endtask

    task automatic t_level;
        @(negedge clk); src_in[1] = 1'b1;
        @(negedge clk); src_in[1] = 1'b0;
        rd_chk(4'hB, 32'h002, "R5 masked source latches");
        chk("R10 masked pending no irq", {31'd0, irq_out}, 32'd0);
        wr(4'h9, 32'h002);
        chk("R10 enabled pending irq", {31'd0, irq_out}, 32'd1);
        wr(4'hB, 32'h000);
        rd_chk(4'hB, 32'h002, "R6 zero write keeps pending");
        wr(4'hB, 32'h002);
        chk("R10 irq drops on clear", {31'd0, irq_out}, 32'd0);
        rd_chk(4'hB, 32'h000, "R6 clear pending");
        // held-high level source re-arms one cycle after clear
        @(negedge clk); src_in[4] = 1'b1;
        @(negedge clk);
        chk("R7 level sets", {31'd0, irq_out}, 32'd1);
        wr(4'hB, 32'h010);
        chk("R7 clear wins at edge", {31'd0, irq_out}, 32'd0);
        @(negedge clk);
        chk("R7 re-arm next cycle", {31'd0, irq_out}, 32'd1);
        src_in[4] = 1'b0;
        wr(4'hB, 32'h010);
        rd_chk(4'hB, 32'h000, "R7 stays clear once low");
    endtask

    task automatic t_edge;
        logic [31:0] rd;
        wr(4'h8, 32'h3FF);
        wr(4'h9, 32'h300);
        @(negedge clk); src_in[8] = 1'b1;
        @(negedge clk);
        chk("R8 rising edge sets", {31'd0, irq_out}, 32'd1);
        wr(4'hB, 32'h100);
        repeat (3) @(negedge clk);
        chk("R8 held high no re-arm irq", {31'd0, irq_out}, 32'd0);
        rd_chk(4'hB, 32'h000, "R8 held high no re-arm status");
        src_in[8] = 1'b0;
        // pulse source 9, then collide its next edge with a clear
        @(negedge clk); src_in[9] = 1'b1;
        @(negedge clk); src_in[9] = 1'b0;
        repeat (2) @(negedge clk);
        rd_chk(4'hB, 32'h200, "R8 pulse latched");
        bus_op(1'b1, 4'hB, 32'h200, 1'b1, 10'h200, rd);
        rd_chk(4'hB, 32'h200, "R9 edge beats clear");
        src_in = '0;
        wr(4'hB, 32'h3FF);
        rd_chk(4'hB, 32'h000, "R6 clear all");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_mask_set();
        t_mask_clr();
        t_level();
        t_edge();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule